// File: doc/BRIEF.md
# Event-Driven Compare-Clear Counter

This block counts transitions of an asynchronous event line rather than ticks of a divided clock. The event line is brought into the system clock domain by a two-flop synchronizer. An edge detector then picks out the transitions that the edge selector allows: rising, falling, both, or none. Each selected transition advances a 16-bit counter by one.

A compare value is written into a register. It is copied into a private buffer when counting starts and again each time the counter wraps. When an event arrives while the count equals the buffered value, the counter goes back to zero.

While stopped, the counter rests at all ones, so the first event after start takes it to zero. A one-cycle interrupt pulse is raised whenever the count reaches the buffered value. As a result, an interrupt appears once every (compare value + 1) events. Counting runs only when the run bit is set and the mode field selects event counting.

Top module: `event_match_counter`

## Requirements
- R1: While the block is not counting, `count` is FFFFH. Clearing `runEn` returns `count` to FFFFH on the next clock edge.
- R2: Each selected event edge increments `count` by one. The first selected edge after counting starts moves `count` from FFFFH to 0000H.
- R3: `edgeSel` encoding: 2'b00 counts no edges, 2'b01 counts rising edges, 2'b10 counts falling edges, 2'b11 counts both.
- R4: When a selected edge arrives while `count` equals the buffered compare value, `count` becomes 0000H.
- R5: `matchIrq` is high for one cycle each time `count` takes the buffered compare value. With a compare value N, there are floor(E/(N+1)) pulses in E edges, and `count` ends at (E-1) mod (N+1).
- R6: The compare buffer loads from the compare register when counting starts and at each wrap to zero. A write made while counting takes effect only after the next wrap.
- R7: Counting happens only when `runEn` is 1 and `modeSel` is 3'b001. Any other `modeSel` value keeps the block stopped.
- R8: While stopped, `matchIrq` stays 0. Stopping in the cycle before a pending match cancels that interrupt.
- R9: A level change on `evtIn` changes `count` on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run bit; 1 lets the counter advance |
| modeSel | input | 3 | Operating mode; 3'b001 selects event counting |
| edgeSel | input | 2 | Selects which event edges are counted |
| cmpWrEn | input | 1 | Write strobe for the compare register |
| cmpWrData | input | 16 | Value written into the compare register |
| evtIn | input | 1 | Asynchronous event line |
| count | output | 16 | Current counter value |
| matchIrq | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
The counting function is exercised with single-edge pulses under rising-only and falling-only selection, and with both-edge selection. Comparing these shows whether the polarity decode counts one transition or two per pulse. A compare value of zero sets an interrupt on every edge, while larger values check the (N+1) period and the final count after the wrap. A "none" selection separates the edge gate from the run gate, and a wrong mode value separates the mode decode from the run bit. Directed runs do three further things: they rewrite the compare value between matches to expose an unbuffered compare, drop the run bit one cycle before a match, and count clock edges from an input change to the counter step.

// File: rtl/emc_pkg.sv
package emc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  localparam logic [2:0] MODE_EVENT = 3'b001;

  typedef struct packed {
    logic active;     // block is counting this cycle
    logic startPulse; // first active cycle after a stop
    logic evEdge;     // a selected event edge is seen this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/emc_ctrl.sv
module emc_ctrl
  import emc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic [2:0]  modeSel,
  input  logic [1:0]  edgeSel,
  input  logic        evtIn,
  output ctrlStrobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncReg;
  logic          lvlPrev;
  logic          activePrev;
  logic          lvlNow;
  logic          riseSeen;
  logic          fallSeen;
  logic          edgeHit;
  logic          activeNow;

  // synchronizer chain for the asynchronous event line
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= evtIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[LAST-1:0], evtIn};
      end
    end
  endgenerate

  assign lvlNow = syncReg[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlPrev    <= 1'b0;
      activePrev <= 1'b0;
    end else begin
      lvlPrev    <= lvlNow;
      activePrev <= activeNow;
    end
  end

  assign riseSeen = lvlNow & ~lvlPrev;
  assign fallSeen = ~lvlNow & lvlPrev;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      EDGE_RISE: edgeHit = riseSeen;
      EDGE_FALL: edgeHit = fallSeen;
      EDGE_BOTH: edgeHit = riseSeen | fallSeen;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign activeNow = runEn && (modeSel == MODE_EVENT);

  always_comb begin
    strobe.active     = activeNow;
    strobe.startPulse = activeNow & ~activePrev;
    strobe.evEdge     = activeNow & edgeHit;
  end

  // R3: with no edge selected, no event ever reaches the datapath
  p_none_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'b00) |-> !strobe.evEdge);

  // R7: a mode other than event counting keeps the block stopped
  p_mode_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_EVENT) |-> !strobe.active);

endmodule

// File: rtl/emc_datapath.sv
module emc_datapath
  import emc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  output logic [WIDTH-1:0] count,
  output logic             matchIrq
);

  localparam logic [WIDTH-1:0] IDLE_VAL = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] cmpReg;
  logic [WIDTH-1:0] cmpBuf;
  logic [WIDTH-1:0] countQ;
  logic             armed;
  logic             irqQ;

  logic             matchNow;
  logic             reload;
  logic [WIDTH-1:0] bufEff;
  logic [WIDTH-1:0] nextCount;
  logic             irqNext;

  always_ff @(posedge clk) begin
    if (!rstN)        cmpReg <= '0;
    else if (cmpWrEn) cmpReg <= cmpWrData;
  end

  always_comb begin
    matchNow = armed && strobe.evEdge && (countQ == cmpBuf);
    reload   = strobe.startPulse || matchNow;
    bufEff   = reload ? cmpReg : cmpBuf;
    if (!armed || matchNow) nextCount = '0;
    else                    nextCount = countQ + ONE;
    irqNext  = strobe.evEdge && (nextCount == bufEff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpBuf <= '0;
      countQ <= IDLE_VAL;
      armed  <= 1'b0;
      irqQ   <= 1'b0;
    end else if (!strobe.active) begin
      countQ <= IDLE_VAL;
      armed  <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      cmpBuf <= bufEff;
      if (strobe.evEdge) begin
        countQ <= nextCount;
        armed  <= 1'b1;
        irqQ   <= irqNext;
      end else begin
        irqQ   <= 1'b0;
      end
    end
  end

  assign count    = countQ;
  assign matchIrq = irqQ;

  // R1: a stopped block rests at all ones
  p_idle_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> (countQ == IDLE_VAL));

  // R2: a counted edge below the match steps by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && armed && strobe.evEdge && countQ != cmpBuf)
      |=> (countQ == $past(countQ) + ONE));

  // R2: without an edge the count does not move
  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !strobe.evEdge) |=> $stable(countQ));

  // R4: an edge at the buffered value clears the count
  p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && armed && strobe.evEdge && countQ == cmpBuf)
      |=> (countQ == '0));

  // R5: the interrupt appears only with the count at the buffered value
  p_irq_at_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |-> (countQ == cmpBuf));

  // R8: a stop cycle never lets an interrupt through
  p_irq_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> !matchIrq);

endmodule

// File: rtl/event_match_counter.sv
module event_match_counter
  import emc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [2:0]       modeSel,
  input  logic [1:0]       edgeSel,
  input  logic             cmpWrEn,
  input  logic [WIDTH-1:0] cmpWrData,
  input  logic             evtIn,
  output logic [WIDTH-1:0] count,
  output logic             matchIrq
);

  ctrlStrobe_t strobe;

  emc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .modeSel (modeSel),
    .edgeSel (edgeSel),
    .evtIn   (evtIn),
    .strobe  (strobe)
  );

  emc_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpWrEn   (cmpWrEn),
    .cmpWrData (cmpWrData),
    .count     (count),
    .matchIrq  (matchIrq)
  );

endmodule

// File: tb/event_match_counter_tb.sv
module event_match_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [2:0]  modeSel = 3'b001;
  logic [1:0]  edgeSel = 2'b01;
  logic        cmpWrEn = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic        evtIn = 1'b0;
  logic [15:0] count;
  logic        matchIrq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;

  always #5 clk = ~clk;

  event_match_counter u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel),
    .edgeSel(edgeSel), .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .evtIn(evtIn), .count(count), .matchIrq(matchIrq)
  );

  always @(negedge clk) if (matchIrq === 1'b1) irqSeen++;

  // vector table: edge select, compare value, pulses
  localparam int NV = 6;
  localparam int vSel[NV]    = '{1, 2, 3, 0, 1, 3};
  localparam int vCmp[NV]    = '{3, 3, 2, 5, 0, 7};
  localparam int vPulses[NV] = '{10, 4, 5, 3, 5, 3};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    evtIn = 1'b1; step(4);
    evtIn = 1'b0; step(4);
  endtask

  task automatic writeCmp(input logic [15:0] v);
    cmpWrData = v; cmpWrEn = 1'b1; step(1); cmpWrEn = 1'b0;
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    step(3);
    // R1 R8: reset state
    check("R1 reset count", 32'(count), 32'hFFFF);
    check("R8 reset irq", 32'(matchIrq), 0);
    rstN = 1'b1;
    step(2);

    // R2 R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      int e;
      int expCnt;
      int expIrq;
      runEn = 1'b0; modeSel = 3'b001; edgeSel = 2'(vSel[i]);
      step(1);
      writeCmp(16'(vCmp[i]));
      runEn = 1'b1; step(2);
      irqSeen = 0;
      for (int p = 0; p < vPulses[i]; p++) pulse();
      e = (vSel[i] == 0) ? 0 : (vSel[i] == 3) ? 2 * vPulses[i] : vPulses[i];
      expCnt = (e == 0) ? 32'hFFFF : (e - 1) % (vCmp[i] + 1);
      expIrq = e / (vCmp[i] + 1);
      check($sformatf("R2 R3 R4 vector %0d count", i), 32'(count), 32'(expCnt));
      check($sformatf("R5 vector %0d irq pulses", i), 32'(irqSeen), 32'(expIrq));
    end

    // R9: latency of three clock edges
    runEn = 1'b0; edgeSel = 2'b01; step(1);
    writeCmp(16'd100);
    runEn = 1'b1; step(2);
    evtIn = 1'b1;
    step(2);
    check("R9 count before third edge", 32'(count), 32'hFFFF);
    step(1);
    check("R9 count at third edge (R2 first edge)", 32'(count), 0);
    step(3); evtIn = 1'b0; step(4);

    // R1: stop returns to FFFF at once, restart begins at 0
    pulse(); pulse();
    check("R2 count after two more edges", 32'(count), 2);
    runEn = 1'b0; step(1);
    check("R1 immediate idle", 32'(count), 32'hFFFF);
    runEn = 1'b1; step(2);
    pulse();
    check("R2 restart first edge", 32'(count), 0);

    // R7: wrong mode keeps the block stopped
    runEn = 1'b0; step(1);
    modeSel = 3'b010; runEn = 1'b1; step(2);
    irqSeen = 0;
    pulse(); pulse(); pulse();
    check("R7 wrong mode count", 32'(count), 32'hFFFF);
    check("R7 wrong mode irq", 32'(irqSeen), 0);

    // R6: write between matches is deferred to the next wrap
    runEn = 1'b0; modeSel = 3'b001; step(1);
    writeCmp(16'd3);
    runEn = 1'b1; step(2);
    irqSeen = 0;
    pulse(); pulse();
    writeCmp(16'd1);
    pulse(); pulse(); pulse();
    check("R6 count after five edges", 32'(count), 0);
    check("R6 irq after five edges", 32'(irqSeen), 1);
    pulse(); pulse();
    check("R6 count after seven edges", 32'(count), 0);
    check("R6 irq after seven edges", 32'(irqSeen), 2);

    // R8: stopping just before a pending match cancels it
    runEn = 1'b0; step(1);
    writeCmp(16'd0);
    runEn = 1'b1; step(2);
    irqSeen = 0;
    evtIn = 1'b1;
    step(2);
    runEn = 1'b0;
    step(4);
    check("R8 cancelled irq", 32'(irqSeen), 0);
    check("R1 count after cancel", 32'(count), 32'hFFFF);
    evtIn = 1'b0; step(4);

    finish();
  end

endmodule